// File: doc/BRIEF.md
# Two-Pin Escape Sequence Detector

This block watches the clock line and the data line of a two-wire debug link and picks out escape sequences. An escape is a burst of data-line transitions made while the clock line is held high. The block counts those transitions during each high phase of the clock line. It hands the count over when the clock line falls. At the following rise of the clock line it turns the count into one of three commands: select (go online), deselect (go offline) or line reset. It then updates a single online/offline flag.

Both line inputs and the optional active-low line reset are oversampled on a fast system clock through a synchronizer chain. All edge detection happens in the system clock domain, so the block has no clock taken from a pin. Downstream logic uses the online flag to decide whether link activity may reach the four-wire test port. It uses the one-cycle command pulses to sequence its own entry and exit.

Top module: `twopin_escape_detector`

## Requirements
- R1: After the synchronous active-high `rst`, `online` is 0 and all three command pulses are 0.
- R2: Data-line transitions made while the clock line is low are never counted. Any number of them, followed by a clock rise after a high phase with no transitions, produces no command.
- R3: A high phase with 0 to 3 data-line transitions produces no command at the next clock rise, and `online` keeps its value.
- R4: A high phase with 4 or 5 transitions gives exactly one `cmd_select` pulse at the next clock rise, and `online` becomes 1 in that same cycle. Only a select command can take `online` from 0 to 1.
- R5: A high phase with 6 or 7 transitions gives exactly one `cmd_deselect` pulse at the next clock rise, and `online` is 0 from that cycle on.
- R6: A high phase with 8 or more transitions gives exactly one `cmd_reset` pulse at the next clock rise, with `online` 0. The count saturates, so a burst of 20 transitions still decodes as reset.
- R7: A command takes effect only at the clock rise that follows the high phase. Between the clock fall and that rise, no pulse appears and `online` does not change.
- R8: A data transition is counted only when the clock line was already high in the sample before it. A transition sampled together with the clock rise is not counted.
- R9: While the synchronized `trst_line_n` is low, `online` is 0 and no command pulse is issued. This holds when the line reset arrives in the same sample as the deciding clock rise.
- R10: The command pulses last one system-clock cycle each, and at most one of them is high at a time.
- R11: The transition count is cleared at every clock fall. Transitions from separate high phases never add up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the link lines |
| rst | input | 1 | Synchronous active-high reset |
| tck_line | input | 1 | Link clock line, asynchronous to `clk` |
| tms_line | input | 1 | Link data line, asynchronous to `clk` |
| trst_line_n | input | 1 | Optional active-low line reset, asynchronous to `clk` |
| online | output | 1 | 1 while the link is selected |
| cmd_select | output | 1 | One-cycle pulse on a decoded select command |
| cmd_deselect | output | 1 | One-cycle pulse on a decoded deselect command |
| cmd_reset | output | 1 | One-cycle pulse on a decoded line-reset command |

## Verification
The line reset and a command decode can land in the same system-clock cycle. The bench provokes this by dropping `trst_line_n` in the same sample in which the clock line rises at the end of a four-transition escape. Both inputs then leave the synchronizer together. The line reset must win: no select pulse may appear and `online` must stay 0. The bench also puts a data transition in the same sample as a clock rise. That transition must be left out of the count, which turns a would-be select into no command.

// File: rtl/twopin_esc_pkg.sv
package twopin_esc_pkg;

  typedef enum logic [1:0] {
    ESC_NONE     = 2'd0,
    ESC_SELECT   = 2'd1,
    ESC_DESELECT = 2'd2,
    ESC_RESET    = 2'd3
  } esc_cmd_e;

  // Sampled view of the three link lines.
  typedef struct packed {
    logic trst_n;
    logic ck;
    logic dat;
  } line_t;

  localparam line_t LINE_IDLE = '{trst_n: 1'b1, ck: 1'b1, dat: 1'b1};

  // Map a transition count onto a command; the ranges are half-open.
  function automatic esc_cmd_e classify(input int unsigned n,
                                        input int unsigned sel_min,
                                        input int unsigned desel_min,
                                        input int unsigned rst_min);
    esc_cmd_e c;
    if (n >= rst_min)        c = ESC_RESET;
    else if (n >= desel_min) c = ESC_DESELECT;
    else if (n >= sel_min)   c = ESC_SELECT;
    else                     c = ESC_NONE;
    return c;
  endfunction

endpackage

// File: rtl/twopin_esc_sync.sv
module twopin_esc_sync
  import twopin_esc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t raw,
  output line_t cur,
  output line_t prv
);

  localparam int DEPTH = STAGES + 1;

  line_t chain [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= LINE_IDLE;
          else     chain[g] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= LINE_IDLE;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign cur = chain[STAGES-1];
  assign prv = chain[STAGES];

endmodule

// File: rtl/twopin_esc_counter.sv
module twopin_esc_counter #(
  parameter int SAT   = 8,
  parameter int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_ok,
  input  logic             ck_cur,
  input  logic             ck_prv,
  input  logic             dat_cur,
  input  logic             dat_prv,
  output logic             ck_rise,
  output logic [CNT_W-1:0] pend
);

  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

  logic             ck_fall;
  logic             dat_edge;
  logic [CNT_W-1:0] run_cnt;

  assign ck_rise  =  ck_cur & ~ck_prv;
  assign ck_fall  = ~ck_cur &  ck_prv;
  // Count only when the clock line was high in both samples.
  assign dat_edge = ck_cur & ck_prv & (dat_cur ^ dat_prv);

  always_ff @(posedge clk) begin
    if (rst || !line_ok) begin
      run_cnt <= '0;
      pend    <= '0;
    end else if (ck_fall) begin
      pend    <= run_cnt;
      run_cnt <= '0;
    end else if (ck_rise) begin
      pend    <= '0;
    end else if (dat_edge && run_cnt < SAT_V) begin
      run_cnt <= run_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/twopin_esc_decode.sv
module twopin_esc_decode
  import twopin_esc_pkg::*;
#(
  parameter int SEL_MIN   = 4,
  parameter int DESEL_MIN = 6,
  parameter int RST_MIN   = 8,
  parameter int CNT_W     = $clog2(RST_MIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_ok,
  input  logic             ck_rise,
  input  logic [CNT_W-1:0] pend,
  output logic             online,
  output logic             cmd_select,
  output logic             cmd_deselect,
  output logic             cmd_reset
);

  esc_cmd_e cmd;

  always_comb begin
    cmd = classify(32'(pend), SEL_MIN, DESEL_MIN, RST_MIN);
  end

  always_ff @(posedge clk) begin
    if (rst || !line_ok) begin
      online       <= 1'b0;
      cmd_select   <= 1'b0;
      cmd_deselect <= 1'b0;
      cmd_reset    <= 1'b0;
    end else begin
      cmd_select   <= 1'b0;
      cmd_deselect <= 1'b0;
      cmd_reset    <= 1'b0;
      if (ck_rise) begin
        unique case (cmd)
          ESC_SELECT: begin
            cmd_select <= 1'b1;
            online     <= 1'b1;
          end
          ESC_DESELECT: begin
            cmd_deselect <= 1'b1;
            online       <= 1'b0;
          end
          ESC_RESET: begin
            cmd_reset <= 1'b1;
            online    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twopin_escape_detector.sv
module twopin_escape_detector
  import twopin_esc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_MIN     = 4,
  parameter int DESEL_MIN   = 6,
  parameter int RST_MIN     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tck_line,
  input  logic tms_line,
  input  logic trst_line_n,
  output logic online,
  output logic cmd_select,
  output logic cmd_deselect,
  output logic cmd_reset
);

  localparam int CNT_W = $clog2(RST_MIN + 1);

  line_t            raw_s;
  line_t            cur_s;
  line_t            prv_s;
  logic             line_ok;
  logic             ck_rise;
  logic [CNT_W-1:0] pend;

  assign raw_s = '{trst_n: trst_line_n, ck: tck_line, dat: tms_line};
  // Line reset releases only after two consecutive high samples.
  assign line_ok = cur_s.trst_n & prv_s.trst_n;

  twopin_esc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw (raw_s),
    .cur (cur_s),
    .prv (prv_s)
  );

  twopin_esc_counter #(.SAT(RST_MIN), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .line_ok (line_ok),
    .ck_cur  (cur_s.ck),
    .ck_prv  (prv_s.ck),
    .dat_cur (cur_s.dat),
    .dat_prv (prv_s.dat),
    .ck_rise (ck_rise),
    .pend    (pend)
  );

  twopin_esc_decode #(
    .SEL_MIN   (SEL_MIN),
    .DESEL_MIN (DESEL_MIN),
    .RST_MIN   (RST_MIN),
    .CNT_W     (CNT_W)
  ) u_decode (
    .clk          (clk),
    .rst          (rst),
    .line_ok      (line_ok),
    .ck_rise      (ck_rise),
    .pend         (pend),
    .online       (online),
    .cmd_select   (cmd_select),
    .cmd_deselect (cmd_deselect),
    .cmd_reset    (cmd_reset)
  );

endmodule

// File: rtl/twopin_escape_detector_chk.sv
module twopin_escape_detector_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic trst_line_n,
  input logic online,
  input logic cmd_select,
  input logic cmd_deselect,
  input logic cmd_reset
);

  localparam int RUN_MAX = SYNC_STAGES + 2;

  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst || trst_line_n) low_run <= 0;
    else if (low_run < RUN_MAX) low_run <= low_run + 1;
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_select, cmd_deselect, cmd_reset})); // R10

  AST_SELECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_select |=> !cmd_select); // R10

  AST_SELECT_SETS_ONLINE: assert property (@(posedge clk) disable iff (rst)
    cmd_select |-> online); // R4

  AST_ONLINE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(online) |-> cmd_select); // R4

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_deselect |-> !online); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |-> !online); // R6

  AST_LINE_RESET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (low_run > SYNC_STAGES) |-> (!online && !cmd_select && !cmd_deselect && !cmd_reset)); // R9

endmodule

bind twopin_escape_detector twopin_escape_detector_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .trst_line_n  (trst_line_n),
  .online       (online),
  .cmd_select   (cmd_select),
  .cmd_deselect (cmd_deselect),
  .cmd_reset    (cmd_reset)
);

// File: tb/twopin_escape_detector_bench.sv
module twopin_escape_detector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSYNC      = 2;
  localparam int HOLD       = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tck_line = 1'b1;
  logic tms_line = 1'b1;
  logic trst_line_n = 1'b1;
  logic online, cmd_select, cmd_deselect, cmd_reset;

  always #(CLK_PERIOD/2) clk = ~clk;

  twopin_escape_detector u_twopin_escape_detector (
    .clk          (clk),
    .rst          (rst),
    .tck_line     (tck_line),
    .tms_line     (tms_line),
    .trst_line_n  (trst_line_n),
    .online       (online),
    .cmd_select   (cmd_select),
    .cmd_deselect (cmd_deselect),
    .cmd_reset    (cmd_reset)
  );

  int    compared   = 0;
  int    mismatched = 0;
  string phase      = "R1";
  bit    done       = 1'b0;
  int    n_sel = 0, n_des = 0, n_rst = 0;

  // Reference model: a delay queue of line samples plus behavioural state.
  logic [2:0] hist[$];   // {trst_n, clock, data}, newest first
  int m_cnt = 0, m_pend = 0;
  bit m_on = 0, m_sel = 0, m_des = 0, m_rst = 0;

  always @(posedge clk) begin
    logic [2:0] s, p;
    bit ok, rise, fall;
    if (rst) begin
      hist.delete();
      for (int i = 0; i <= NSYNC; i++) hist.push_back(3'b111);
      m_cnt = 0; m_pend = 0; m_on = 0; m_sel = 0; m_des = 0; m_rst = 0;
    end else begin
      s = hist[NSYNC-1];
      p = hist[NSYNC];
      ok   = s[2] && p[2];
      rise = s[1] && !p[1];
      fall = !s[1] && p[1];
      m_sel = 0; m_des = 0; m_rst = 0;
      if (!ok) begin
        m_cnt = 0; m_pend = 0; m_on = 0;
      end else begin
        if (rise) begin
          if (m_pend >= 8)      begin m_rst = 1; m_on = 0; end
          else if (m_pend >= 6) begin m_des = 1; m_on = 0; end
          else if (m_pend >= 4) begin m_sel = 1; m_on = 1; end
          m_pend = 0;
        end else if (fall) begin
          m_pend = m_cnt;
          m_cnt  = 0;
        end else if (s[1] && p[1] && (s[0] != p[0]) && m_cnt < 8) begin
          m_cnt = m_cnt + 1;
        end
      end
      hist.push_front({trst_line_n, tck_line, tms_line});
      void'(hist.pop_back());
    end
  end

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if ({online, cmd_select, cmd_deselect, cmd_reset} !== {m_on, m_sel, m_des, m_rst}) begin
        mismatched++;
        $display("FAIL %s: outputs {on,sel,des,rst} actual %b expected %b", phase,
                 {online, cmd_select, cmd_deselect, cmd_reset}, {m_on, m_sel, m_des, m_rst});
      end
      if (cmd_select)   n_sel++;
      if (cmd_deselect) n_des++;
      if (cmd_reset)    n_rst++;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic clear_seen();
    n_sel = 0; n_des = 0; n_rst = 0;
  endtask

  task automatic expect_cmds(input string req, input int sel, input int des, input int rs, input int on);
    chk(req, "select pulses", n_sel, sel);
    chk(req, "deselect pulses", n_des, des);
    chk(req, "reset pulses", n_rst, rs);
    chk(req, "online", int'(online), on);
  endtask

  task automatic toggle_dat();
    tms_line = ~tms_line;
    step(HOLD);
  endtask

  task automatic high_phase(input int n);
    tck_line = 1'b1;
    step(4);
    repeat (n) toggle_dat();
    step(2);
    tck_line = 1'b0;
    step(5);
  endtask

  task automatic escape(input int n);
    clear_seen();
    high_phase(n);
    tck_line = 1'b1;
    step(8);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step(3);
    // R1: reset state
    phase = "R1";
    expect_cmds("R1", 0, 0, 0, 0);

    phase = "R3";
    escape(3);
    expect_cmds("R3", 0, 0, 0, 0);

    phase = "R4";
    escape(4);
    expect_cmds("R4", 1, 0, 0, 1);
    escape(5);
    expect_cmds("R4", 1, 0, 0, 1);
    escape(2);
    expect_cmds("R3", 0, 0, 0, 1);

    phase = "R5";
    escape(6);
    expect_cmds("R5", 0, 1, 0, 0);
    escape(7);
    expect_cmds("R5", 0, 1, 0, 0);

    phase = "R6";
    escape(5);
    escape(8);
    expect_cmds("R6", 0, 0, 1, 0);
    escape(4);
    escape(20);
    expect_cmds("R6", 0, 0, 1, 0);

    phase = "R11";
    clear_seen();
    high_phase(3);
    high_phase(3);
    tck_line = 1'b1;
    step(8);
    expect_cmds("R11", 0, 0, 0, 0);

    phase = "R2";
    clear_seen();
    high_phase(0);
    repeat (9) toggle_dat();
    tck_line = 1'b1;
    step(8);
    expect_cmds("R2", 0, 0, 0, 0);

    phase = "R7";
    clear_seen();
    high_phase(4);
    step(10);
    expect_cmds("R7", 0, 0, 0, 0);
    tck_line = 1'b1;
    step(8);
    expect_cmds("R7", 1, 0, 0, 1);
    escape(6);

    phase = "R8";
    clear_seen();
    tck_line = 1'b0;
    step(4);
    tck_line = 1'b1;
    tms_line = ~tms_line;
    step(HOLD);
    repeat (3) toggle_dat();
    step(2);
    tck_line = 1'b0;
    step(5);
    tck_line = 1'b1;
    step(8);
    expect_cmds("R8", 0, 0, 0, 0);

    phase = "R9";
    escape(4);
    trst_line_n = 1'b0;
    step(6);
    expect_cmds("R9", 1, 0, 0, 0);
    escape(4);
    expect_cmds("R9", 0, 0, 0, 0);
    trst_line_n = 1'b1;
    step(4);
    clear_seen();
    high_phase(4);
    tck_line    = 1'b1;
    trst_line_n = 1'b0;
    step(8);
    expect_cmds("R9", 0, 0, 0, 0);
    trst_line_n = 1'b1;
    step(4);
    escape(5);
    expect_cmds("R9", 1, 0, 0, 1);

    phase = "R10";
    escape(8);
    expect_cmds("R10", 0, 0, 1, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule